// File: doc/BRIEF.md
# One-Bit Stream Error Corrector

This block sits between a 1-bit pulse-density audio source and a switching power stage. On every cycle where a rate strobe marks a new bit, it takes one source bit and one feedback bit. The feedback bit comes from an external comparator that watches the amplifier output: 1 means the sensed output rose since the previous sample, 0 means it fell or held. When the two bits disagree, the block flags an error. If correction is enabled, it drives the following output bit to the level the source asked for, in place of the next source bit.

Alongside the correction path, both streams are shifted side by side into 32-bit words for offline comparison. Every 32 strobes a pair of words is published with a one-cycle valid pulse, and capture goes on without a gap. A saturating counter totals disagreeing bit pairs. At a 2.8224 MHz bit rate the word rate is 88.2 kHz.

Top module: `onebit_fb_corrector`

## Requirements
- R1: All state (output bit, error flag, capture registers, counter) changes only on clock cycles where `bit_en` is 1. While `bit_en` is 0, the outputs and the capture contents hold whatever `src_bit` and `fb_bit` do.
- R2: On a strobe, `err_bit` becomes 1 at the next clock edge if `src_bit` differs from `fb_bit`, and 0 otherwise. It holds that value until the next strobe.
- R3: If the previous strobe left no error, or `corr_en` is 0 on the current strobe, `out_bit` takes the current `src_bit` at the clock edge of that strobe, so the latency is one cycle.
- R4: If the previous strobe left an error and `corr_en` is 1, `out_bit` takes that earlier source bit instead of the current one. Source 1 with feedback 0 forces 1; source 0 with feedback 1 forces 0.
- R5: Bits enter each word oldest first. The first bit of a word ends at bit 31 and the last at bit 0. `src_word` and `fb_word` update together, with `word_valid` high for exactly one clock after every 32nd strobe since reset.
- R6: The strobe after a completed word is bit 31 of the next word, so no bit is lost between words.
- R7: `mismatch_cnt` adds one on every strobe whose bits disagree, stops at 65535, and is zeroed by `cnt_clr`. A clear wins over a simultaneous increment.
- R8: A synchronous `rst` clears the capture registers, the bit position, the published words, `word_valid`, the pending error, `out_bit` and the counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_en | input | 1 | One-cycle strobe per stream bit |
| src_bit | input | 1 | Source stream bit |
| fb_bit | input | 1 | Feedback direction bit (1 = output rose) |
| corr_en | input | 1 | Enables the override of the next bit |
| cnt_clr | input | 1 | Synchronous clear of the mismatch counter |
| out_bit | output | 1 | Bit sent to the power stage |
| err_bit | output | 1 | Error of the last strobed bit pair |
| word_valid | output | 1 | One-cycle pulse when new words are published |
| src_word | output | 32 | Last completed source word, oldest bit at 31 |
| fb_word | output | 32 | Last completed feedback word, oldest bit at 31 |
| mismatch_cnt | output | 16 | Saturating count of disagreeing pairs |

## Verification
A stale pending-error flag shows up on `out_bit` at the very next strobe: a forced level replaces the source bit, or a forced level is missing. A bit-position counter that is out of step moves the `word_valid` pulse off the 32-strobe grid. A shift register that slips by one position rotates the published words. Both faults appear at the first word boundary, at most 32 strobes after the fault. A counter that wraps instead of holding shows as a small value after a long run of mismatches, so the bench runs it past its limit.

// File: rtl/fbc_pkg.sv
`timescale 1ns/1ps
package fbc_pkg;
  // Error rule: a mismatch between requested and observed direction.
  function automatic logic pair_error(input logic src, input logic fb);
    return src ^ fb;
  endfunction

  // Level forced after a mismatch: the direction the source asked for.
  function automatic logic forced_level(input logic src);
    return src;
  endfunction

  // Output selection for one strobe.
  function automatic logic pick_out(input logic src, input logic ovr, input logic lvl);
    return ovr ? lvl : src;
  endfunction
endpackage

// File: rtl/fbc_decide.sv
`timescale 1ns/1ps
module fbc_decide (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic src_bit,
  input  logic fb_bit,
  input  logic corr_en,
  output logic out_bit,
  output logic pend,
  output logic pend_lvl
);
  logic now_err;
  logic apply_ovr;

  assign now_err   = fbc_pkg::pair_error(src_bit, fb_bit);
  assign apply_ovr = pend & corr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_bit  <= 1'b0;
      pend     <= 1'b0;
      pend_lvl <= 1'b0;
    end else if (bit_en) begin
      out_bit  <= fbc_pkg::pick_out(src_bit, apply_ovr, pend_lvl);
      pend     <= now_err;
      pend_lvl <= fbc_pkg::forced_level(src_bit);
    end
  end
endmodule

// File: rtl/fbc_capture.sv
`timescale 1ns/1ps
module fbc_capture #(
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              src_bit,
  input  logic              fb_bit,
  output logic [WORD_W-1:0] src_word,
  output logic [WORD_W-1:0] fb_word,
  output logic              word_valid,
  output logic              word_done
);
  localparam int IDX_W = $clog2(WORD_W);
  localparam logic [IDX_W-1:0] LAST = IDX_W'(WORD_W - 1);

  logic [WORD_W-1:0] sh_src, sh_fb;
  logic [WORD_W-1:0] nxt_src, nxt_fb;
  logic [IDX_W-1:0]  idx;

  assign nxt_src   = {sh_src[WORD_W-2:0], src_bit};
  assign nxt_fb    = {sh_fb[WORD_W-2:0], fb_bit};
  assign word_done = bit_en && (idx == LAST);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_src     <= '0;
      sh_fb      <= '0;
      idx        <= '0;
      src_word   <= '0;
      fb_word    <= '0;
      word_valid <= 1'b0;
    end else begin
      word_valid <= 1'b0;
      if (bit_en) begin
        sh_src <= nxt_src;
        sh_fb  <= nxt_fb;
        if (idx == LAST) begin
          idx        <= '0;
          src_word   <= nxt_src;
          fb_word    <= nxt_fb;
          word_valid <= 1'b1;
        end else begin
          idx <= idx + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/fbc_tally.sv
`timescale 1ns/1ps
module fbc_tally #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bump,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  always_ff @(posedge clk) begin
    if (rst || clr)
      cnt <= '0;
    else if (bump && (cnt != CNT_MAX))
      cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/onebit_fb_corrector.sv
`timescale 1ns/1ps
module onebit_fb_corrector #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bit_en,
  input  logic              src_bit,
  input  logic              fb_bit,
  input  logic              corr_en,
  input  logic              cnt_clr,
  output logic              out_bit,
  output logic              err_bit,
  output logic              word_valid,
  output logic [WORD_W-1:0] src_word,
  output logic [WORD_W-1:0] fb_word,
  output logic [CNT_W-1:0]  mismatch_cnt
);
  // Named internal events, observed by the bound checker.
  logic ovr_pend;
  logic force_val;
  logic word_done;
  logic mis_strobe;

  assign mis_strobe = bit_en & fbc_pkg::pair_error(src_bit, fb_bit);
  assign err_bit    = ovr_pend;

  fbc_decide decide_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .src_bit(src_bit), .fb_bit(fb_bit),
    .corr_en(corr_en), .out_bit(out_bit), .pend(ovr_pend), .pend_lvl(force_val)
  );

  fbc_capture #(.WORD_W(WORD_W)) capture_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .src_bit(src_bit), .fb_bit(fb_bit),
    .src_word(src_word), .fb_word(fb_word), .word_valid(word_valid),
    .word_done(word_done)
  );

  fbc_tally #(.CNT_W(CNT_W)) tally_i (
    .clk(clk), .rst(rst), .bump(mis_strobe), .clr(cnt_clr), .cnt(mismatch_cnt)
  );
endmodule

// File: rtl/onebit_fb_corrector_chk.sv
`timescale 1ns/1ps
module onebit_fb_corrector_chk #(
  parameter int WORD_W = 32,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              bit_en,
  input logic              src_bit,
  input logic              fb_bit,
  input logic              corr_en,
  input logic              cnt_clr,
  input logic              out_bit,
  input logic              err_bit,
  input logic              word_valid,
  input logic [WORD_W-1:0] src_word,
  input logic [WORD_W-1:0] fb_word,
  input logic [CNT_W-1:0]  mismatch_cnt,
  input logic              ovr_pend,
  input logic              force_val,
  input logic              word_done
);
  localparam logic [CNT_W-1:0] TOP = '1;

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(out_bit) && $stable(err_bit) && $stable(src_word)); // R1
  AST_ERR_FOLLOWS: assert property (@(posedge clk) disable iff (rst)
    bit_en |=> err_bit == ($past(src_bit) != $past(fb_bit))); // R2
  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (rst)
    bit_en && !(ovr_pend && corr_en) |=> out_bit == $past(src_bit)); // R3
  AST_FORCE_LEVEL: assert property (@(posedge clk) disable iff (rst)
    bit_en && ovr_pend && corr_en |=> out_bit == $past(force_val)); // R4
  AST_VALID_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    word_done |=> word_valid); // R5
  AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid); // R5
  AST_WORDS_ON_VALID: assert property (@(posedge clk) disable iff (rst)
    !$stable(src_word) || !$stable(fb_word) |-> word_valid); // R5
  AST_CNT_SATURATES: assert property (@(posedge clk) disable iff (rst)
    mismatch_cnt == TOP && !cnt_clr |=> mismatch_cnt == TOP); // R7
  AST_CNT_CLEARS: assert property (@(posedge clk) disable iff (rst)
    cnt_clr |=> mismatch_cnt == '0); // R7
endmodule

bind onebit_fb_corrector onebit_fb_corrector_chk #(.WORD_W(WORD_W), .CNT_W(CNT_W)) chk_i (
  .clk(clk), .rst(rst), .bit_en(bit_en), .src_bit(src_bit), .fb_bit(fb_bit),
  .corr_en(corr_en), .cnt_clr(cnt_clr), .out_bit(out_bit), .err_bit(err_bit),
  .word_valid(word_valid), .src_word(src_word), .fb_word(fb_word),
  .mismatch_cnt(mismatch_cnt), .ovr_pend(ovr_pend), .force_val(force_val),
  .word_done(word_done)
);

// File: tb/onebit_fb_corrector_tb_top.sv
`timescale 1ns/1ps
module onebit_fb_corrector_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0, src_bit = 1'b0, fb_bit = 1'b0, corr_en = 1'b0, cnt_clr = 1'b0;
  logic out_bit, err_bit, word_valid;
  logic [31:0] src_word, fb_word;
  logic [15:0] mismatch_cnt;

  int n_checks = 0;
  int n_fails  = 0;
  int vpulses  = 0;

  always #10 clk = ~clk;

  onebit_fb_corrector dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .src_bit(src_bit), .fb_bit(fb_bit),
    .corr_en(corr_en), .cnt_clr(cnt_clr), .out_bit(out_bit), .err_bit(err_bit),
    .word_valid(word_valid), .src_word(src_word), .fb_word(fb_word),
    .mismatch_cnt(mismatch_cnt)
  );

  // {src, fb, corr_en, expected out_bit, expected err_bit}
  localparam logic [4:0] VEC [12] = '{
    5'b11110, 5'b10111, 5'b00110, 5'b01101, 5'b11100, 5'b10011,
    5'b00000, 5'b01001, 5'b11100, 5'b10111, 5'b11110, 5'b00100
  };

  task automatic check(input string tag, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One strobe, then one idle cycle with inverted bits that must be ignored.
  task automatic strobe(input logic s, input logic f, input logic c);
    @(negedge clk);
    bit_en = 1'b1; src_bit = s; fb_bit = f; corr_en = c;
    @(posedge clk);
    @(negedge clk);
    bit_en = 1'b0; src_bit = ~s; fb_bit = ~f;
    if (word_valid) vpulses++;
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1; bit_en = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #3_800_000;
    n_fails++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end

  initial begin
    logic [31:0] es, ef;
    logic        held;
    repeat (3) @(negedge clk);
    check("R8 out_bit after reset", out_bit, 0);
    check("R8 word_valid after reset", word_valid, 0);
    check("R8 counter after reset", mismatch_cnt, 0);
    rst = 1'b0;

    // Table walk: pass-through, override, correction disabled.
    for (int i = 0; i < 12; i++) begin
      strobe(VEC[i][4], VEC[i][3], VEC[i][2]);
      check($sformatf("R3/R4 out_bit vec %0d", i), out_bit, VEC[i][1]);
      check($sformatf("R2 err_bit vec %0d", i), err_bit, VEC[i][0]);
    end
    check("R7 mismatch count after table", mismatch_cnt, 5);

    // R1: idle cycles with changing inputs leave outputs alone.
    held = out_bit;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk); src_bit = k[0]; fb_bit = ~k[0]; corr_en = 1'b1;
    end
    @(negedge clk);
    check("R1 out_bit held while idle", out_bit, held);
    check("R1 counter held while idle", mismatch_cnt, 5);

    // R7: clear wins over a simultaneous mismatching strobe.
    @(negedge clk); cnt_clr = 1'b1; bit_en = 1'b1; src_bit = 1'b1; fb_bit = 1'b0;
    @(negedge clk); cnt_clr = 1'b0; bit_en = 1'b0;
    check("R7 clear beats increment", mismatch_cnt, 0);

    // R8: reset mid-word, then capture must restart at bit 31.
    for (int k = 0; k < 7; k++) strobe(1'b1, 1'b0, 1'b1);
    do_reset();
    check("R8 err_bit cleared", err_bit, 0);
    check("R8 src_word cleared", src_word, 0);
    check("R8 counter cleared", mismatch_cnt, 0);

    // R5: first word, oldest bit at 31.
    vpulses = 0;
    es = '0; ef = '0;
    for (int k = 0; k < 32; k++) begin
      logic s, f;
      s = (k % 3) == 0; f = k[0];
      es[31-k] = s; ef[31-k] = f;
      strobe(s, f, 1'b0);
      if (k == 30) check("R5 no valid before 32nd strobe", vpulses, 0);
    end
    check("R5 one valid pulse per word", vpulses, 1);
    check("R5 src_word ordering", src_word, es);
    check("R5 fb_word ordering", fb_word, ef);
    @(negedge clk);
    check("R5 valid lasts one cycle", word_valid, 0);

    // R6: next word follows with no lost bit.
    es = '0; ef = '0;
    for (int k = 0; k < 32; k++) begin
      logic s, f;
      s = k[1]; f = (k % 5) == 0;
      es[31-k] = s; ef[31-k] = f;
      strobe(s, f, 1'b1);
    end
    check("R6 second src_word", src_word, es);
    check("R6 second fb_word", fb_word, ef);
    check("R6 two valid pulses", vpulses, 2);

    // R7: saturation with continuous strobes.
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    bit_en = 1'b1; src_bit = 1'b1; fb_bit = 1'b0;
    repeat (65600) @(negedge clk);
    bit_en = 1'b0;
    @(negedge clk);
    check("R7 counter saturates", mismatch_cnt, 16'hFFFF);
    @(negedge clk); cnt_clr = 1'b1;
    @(negedge clk); cnt_clr = 1'b0;
    check("R7 clear after saturation", mismatch_cnt, 0);

    $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
    $finish;
  end
endmodule